// File: doc/BRIEF.md
# Issue Selection Window with Busy-Bit Wakeup

This block holds a small pool of renamed instructions that wait to be sent to execution units. Every cycle it judges each waiting entry ready or not from the busy bits of its two source physical registers. Among the ready entries it picks, for each unit class, the oldest ones, up to the number of units of that class free in this cycle. Entries that are picked leave the pool at the next clock edge. Entries that are not picked stay and compete again in a later cycle.

The block keeps the busy bit table itself. An entry inserted with a destination marks that physical register busy. A completion broadcast clears the busy bit of the register it names, and this wakes any consumer on the following cycle. Cache-access entries have two extra gates. They wait until their address is marked generated, which happens through a per-slot notification. They are also limited by free cache ports and not by address units. Upstream rename is expected never to give a new destination the same register as one of that instruction's own sources.

Top module: `iss_sched`

## Requirements
- R1: After reset the pool is empty, every busy bit is clear, `ins_ready` is 1, `iss_grant` is 0, `ins_slot` is 0 and every `used_*` count is 0.
- R2: An accepted insert (`ins_valid` with `ins_ready`) goes to the lowest-numbered empty slot, and that slot number is shown on `ins_slot` in the same cycle. `ins_ready` is 0 exactly when every slot is occupied.
- R3: An insert with `ins_dst_en` set marks physical register `ins_dst` busy from the next cycle.
- R4: An entry can be granted only when neither of its source physical registers is busy.
- R5: A completion (`wb_valid`, `wb_reg`) clears that register's busy bit at the clock edge. A waiting consumer is not granted in the completion cycle itself, but it can be granted in the cycle after. If an insert sets the same register busy in the same cycle, the set wins.
- R6: Class codes are ALU=0, FPU=1, ADDR=2 and cache access=3. The number of grants in each class is at most the smaller of that class's `avail_*` input and its unit-count parameter.
- R7: Within one class, ready entries are granted from oldest to youngest by insertion order, regardless of slot number.
- R8: The classes do not compete. Grants of one class do not depend on entries or availability of another class.
- R9: A cache-access entry is ready only after `agen_valid` has named its slot in an earlier cycle. It uses `avail_port` and is never counted in `used_addr`.
- R10: A granted entry leaves the pool at the next edge, and its slot can be reused from then on. A ready entry that is not granted stays and is granted in a later cycle.
- R11: `used_alu`, `used_fpu`, `used_addr` and `used_port` equal the number of grants of class 0, 1, 2 and 3 in the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert request |
| ins_class | input | 2 | Unit class of the inserted entry (0 ALU, 1 FPU, 2 ADDR, 3 cache access) |
| ins_src_a | input | $clog2(PREG_CNT) | First source physical register |
| ins_src_b | input | $clog2(PREG_CNT) | Second source physical register |
| ins_dst_en | input | 1 | Inserted entry writes a destination |
| ins_dst | input | $clog2(PREG_CNT) | Destination physical register, set busy on insert |
| ins_ready | output | 1 | At least one slot is empty |
| ins_slot | output | $clog2(WIN_DEPTH) | Slot that an insert in this cycle occupies |
| wb_valid | input | 1 | Completion broadcast valid |
| wb_reg | input | $clog2(PREG_CNT) | Physical register whose busy bit is cleared |
| agen_valid | input | 1 | Address generated for a cache-access entry |
| agen_slot | input | $clog2(WIN_DEPTH) | Slot whose address is now known |
| avail_alu | input | $clog2(WIN_DEPTH+1) | ALUs free this cycle |
| avail_fpu | input | $clog2(WIN_DEPTH+1) | FPUs free this cycle |
| avail_addr | input | $clog2(WIN_DEPTH+1) | Address units free this cycle |
| avail_port | input | $clog2(WIN_DEPTH+1) | Cache ports free this cycle |
| iss_grant | output | WIN_DEPTH | One bit per slot granted this cycle |
| used_alu | output | $clog2(WIN_DEPTH+1) | ALU grants this cycle |
| used_fpu | output | $clog2(WIN_DEPTH+1) | FPU grants this cycle |
| used_addr | output | $clog2(WIN_DEPTH+1) | Address-unit grants this cycle |
| used_port | output | $clog2(WIN_DEPTH+1) | Cache-port grants this cycle |

## Verification
The hardest state to reach from the ports is a full pool of same-class consumers whose producers have already left the pool while their results are still pending. This is the only way to get an arbitrary mix of ready and blocked entries. The stimulus first inserts and issues producers that set the busy bits, then completes a chosen subset of them, and then fills the pool with consumers. It sweeps all sixteen readiness masks against every availability count, and each grant vector is compared with the oldest-first pick computed in the bench. A further sequence frees a low slot and refills it, so that the youngest entry sits at the lowest index and slot order differs from age order.

// File: rtl/iss_pkg.sv
package iss_pkg;

  typedef enum logic [1:0] {
    CLS_ALU = 2'd0,
    CLS_FPU = 2'd1,
    CLS_AGU = 2'd2,
    CLS_MEM = 2'd3
  } iss_class_e;

  localparam int NUM_CLASSES = 4;

  function automatic int clamp_units(input int units, input int depth);
    return (units > depth) ? depth : units;
  endfunction

endpackage

// File: rtl/iss_busy_table.sv
module iss_busy_table #(
  parameter int PREG_CNT = 32,
  localparam int PW = $clog2(PREG_CNT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [PW-1:0]       set_reg,
  input  logic                clr_en,
  input  logic [PW-1:0]       clr_reg,
  output logic [PREG_CNT-1:0] busy_o
);

  logic [PREG_CNT-1:0] busy_q;
  logic [PREG_CNT-1:0] busy_d;
  logic                upd_en;

  assign upd_en = set_en | clr_en;

  always_comb begin
    busy_d = busy_q;
    if (clr_en) busy_d[clr_reg] = 1'b0;
    if (set_en) busy_d[set_reg] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
    end else if (upd_en) begin
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;

  assert_dst_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> busy_q[$past(set_reg)]);

  assert_wb_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(set_en && set_reg == clr_reg)) |=> !busy_q[$past(clr_reg)]);

endmodule

// File: rtl/iss_window.sv
module iss_window #(
  parameter int WIN_DEPTH = 8,
  parameter int PREG_CNT  = 32,
  localparam int PW = $clog2(PREG_CNT),
  localparam int SW = $clog2(WIN_DEPTH)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                ins_en,
  input  logic [1:0]                          ins_cls,
  input  logic [PW-1:0]                       ins_src_a,
  input  logic [PW-1:0]                       ins_src_b,
  input  logic                                agen_en,
  input  logic [SW-1:0]                       agen_slot,
  input  logic [WIN_DEPTH-1:0]                grant,
  output logic [WIN_DEPTH-1:0]                vld_o,
  output logic [WIN_DEPTH-1:0][1:0]           cls_o,
  output logic [WIN_DEPTH-1:0][PW-1:0]        srca_o,
  output logic [WIN_DEPTH-1:0][PW-1:0]        srcb_o,
  output logic [WIN_DEPTH-1:0]                addr_ok_o,
  output logic [WIN_DEPTH-1:0][WIN_DEPTH-1:0] older_o,
  output logic                                free_any_o,
  output logic [SW-1:0]                       free_slot_o
);

  logic [WIN_DEPTH-1:0]                vld_q, vld_d;
  logic [WIN_DEPTH-1:0]                addr_q, addr_d;
  logic [WIN_DEPTH-1:0][WIN_DEPTH-1:0] older_q, older_d;
  logic [WIN_DEPTH-1:0][1:0]           cls_q;
  logic [WIN_DEPTH-1:0][PW-1:0]        srca_q, srcb_q;
  logic [WIN_DEPTH-1:0]                ld_en;
  logic                                free_any;
  logic [SW-1:0]                       free_slot;
  logic                                ctl_en;

  // lowest empty slot wins
  always_comb begin
    free_any  = ~(&vld_q);
    free_slot = '0;
    for (int i = WIN_DEPTH - 1; i >= 0; i--) begin
      if (!vld_q[i]) free_slot = SW'(i);
    end
  end

  always_comb begin
    vld_d   = vld_q & ~grant;
    addr_d  = addr_q;
    older_d = older_q;
    ld_en   = '0;
    if (ins_en) begin
      ld_en[free_slot]  = 1'b1;
      vld_d[free_slot]  = 1'b1;
      addr_d[free_slot] = 1'b0;
      for (int j = 0; j < WIN_DEPTH; j++) begin
        older_d[j][free_slot] = vld_q[j];
      end
      for (int j = 0; j < WIN_DEPTH; j++) begin
        older_d[free_slot][j] = 1'b0;
      end
    end
    if (agen_en && vld_q[agen_slot]) addr_d[agen_slot] = 1'b1;
  end

  assign ctl_en = ins_en | agen_en | (|grant);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= '0;
      addr_q  <= '0;
      older_q <= '0;
    end else if (ctl_en) begin
      vld_q   <= vld_d;
      addr_q  <= addr_d;
      older_q <= older_d;
    end
  end

  // payload needs no reset: qualified by vld_q everywhere
  always_ff @(posedge clk) begin
    for (int i = 0; i < WIN_DEPTH; i++) begin
      if (ld_en[i]) begin
        cls_q[i]  <= ins_cls;
        srca_q[i] <= ins_src_a;
        srcb_q[i] <= ins_src_b;
      end
    end
  end

  assign vld_o       = vld_q;
  assign cls_o       = cls_q;
  assign srca_o      = srca_q;
  assign srcb_o      = srcb_q;
  assign addr_ok_o   = addr_q;
  assign older_o     = older_q;
  assign free_any_o  = free_any;
  assign free_slot_o = free_slot;

  assert_insert_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |=> vld_q[$past(free_slot)]);

  assert_grant_on_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~vld_q) == '0);

  for (genvar g = 0; g < WIN_DEPTH; g++) begin : g_leave
    assert_grant_leaves_R10: assert property (@(posedge clk) disable iff (!rst_n)
      grant[g] |=> !vld_q[g]);
  end

endmodule

// File: rtl/iss_select.sv
module iss_select
  import iss_pkg::*;
#(
  parameter int WIN_DEPTH = 8,
  parameter int NUM_ALU   = 2,
  parameter int NUM_FPU   = 1,
  parameter int NUM_AGU   = 1,
  parameter int NUM_PORT  = 1,
  localparam int CW = $clog2(WIN_DEPTH + 1)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [WIN_DEPTH-1:0]                rdy,
  input  logic [WIN_DEPTH-1:0][1:0]           cls,
  input  logic [WIN_DEPTH-1:0][WIN_DEPTH-1:0] older,
  input  logic [CW-1:0]                       avail_alu,
  input  logic [CW-1:0]                       avail_fpu,
  input  logic [CW-1:0]                       avail_agu,
  input  logic [CW-1:0]                       avail_port,
  output logic [WIN_DEPTH-1:0]                grant,
  output logic [NUM_CLASSES-1:0][CW-1:0]      used
);

  localparam int LIM_ALU  = clamp_units(NUM_ALU,  WIN_DEPTH);
  localparam int LIM_FPU  = clamp_units(NUM_FPU,  WIN_DEPTH);
  localparam int LIM_AGU  = clamp_units(NUM_AGU,  WIN_DEPTH);
  localparam int LIM_PORT = clamp_units(NUM_PORT, WIN_DEPTH);

  logic [NUM_CLASSES-1:0][CW-1:0] lim;
  logic [WIN_DEPTH-1:0][CW-1:0]   rank;

  always_comb begin
    lim[CLS_ALU] = (avail_alu  > CW'(LIM_ALU))  ? CW'(LIM_ALU)  : avail_alu;
    lim[CLS_FPU] = (avail_fpu  > CW'(LIM_FPU))  ? CW'(LIM_FPU)  : avail_fpu;
    lim[CLS_AGU] = (avail_agu  > CW'(LIM_AGU))  ? CW'(LIM_AGU)  : avail_agu;
    lim[CLS_MEM] = (avail_port > CW'(LIM_PORT)) ? CW'(LIM_PORT) : avail_port;
  end

  // rank = number of older ready entries of the same class
  for (genvar i = 0; i < WIN_DEPTH; i++) begin : g_rank
    always_comb begin
      rank[i] = '0;
      for (int j = 0; j < WIN_DEPTH; j++) begin
        if (j != i && rdy[j] && older[j][i] && cls[j] == cls[i]) begin
          rank[i] = rank[i] + CW'(1);
        end
      end
      grant[i] = rdy[i] && (rank[i] < lim[cls[i]]);
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CLASSES; c++) begin
      used[c] = '0;
      for (int i = 0; i < WIN_DEPTH; i++) begin
        if (grant[i] && cls[i] == 2'(c)) used[c] = used[c] + CW'(1);
      end
    end
  end

  assert_alu_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    used[CLS_ALU] <= avail_alu && used[CLS_ALU] <= CW'(LIM_ALU));
  assert_fpu_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    used[CLS_FPU] <= avail_fpu && used[CLS_FPU] <= CW'(LIM_FPU));
  assert_agu_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    used[CLS_AGU] <= avail_agu && used[CLS_AGU] <= CW'(LIM_AGU));
  assert_port_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    used[CLS_MEM] <= avail_port && used[CLS_MEM] <= CW'(LIM_PORT));

  for (genvar a = 0; a < WIN_DEPTH; a++) begin : g_age_a
    for (genvar b = 0; b < WIN_DEPTH; b++) begin : g_age_b
      if (a != b) begin : g_pair
        assert_oldest_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
          (grant[a] && rdy[b] && older[b][a] && cls[b] == cls[a]) |-> grant[b]);
      end
    end
  end

endmodule

// File: rtl/iss_sched.sv
module iss_sched
  import iss_pkg::*;
#(
  parameter int WIN_DEPTH = 8,
  parameter int PREG_CNT  = 32,
  parameter int NUM_ALU   = 2,
  parameter int NUM_FPU   = 1,
  parameter int NUM_AGU   = 1,
  parameter int NUM_PORT  = 1,
  localparam int PW = $clog2(PREG_CNT),
  localparam int SW = $clog2(WIN_DEPTH),
  localparam int CW = $clog2(WIN_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ins_valid,
  input  logic [1:0]           ins_class,
  input  logic [PW-1:0]        ins_src_a,
  input  logic [PW-1:0]        ins_src_b,
  input  logic                 ins_dst_en,
  input  logic [PW-1:0]        ins_dst,
  output logic                 ins_ready,
  output logic [SW-1:0]        ins_slot,
  input  logic                 wb_valid,
  input  logic [PW-1:0]        wb_reg,
  input  logic                 agen_valid,
  input  logic [SW-1:0]        agen_slot,
  input  logic [CW-1:0]        avail_alu,
  input  logic [CW-1:0]        avail_fpu,
  input  logic [CW-1:0]        avail_addr,
  input  logic [CW-1:0]        avail_port,
  output logic [WIN_DEPTH-1:0] iss_grant,
  output logic [CW-1:0]        used_alu,
  output logic [CW-1:0]        used_fpu,
  output logic [CW-1:0]        used_addr,
  output logic [CW-1:0]        used_port
);

  logic [PREG_CNT-1:0]                 busy;
  logic [WIN_DEPTH-1:0]                vld;
  logic [WIN_DEPTH-1:0][1:0]           cls;
  logic [WIN_DEPTH-1:0][PW-1:0]        srca, srcb;
  logic [WIN_DEPTH-1:0]                addr_ok;
  logic [WIN_DEPTH-1:0][WIN_DEPTH-1:0] older;
  logic [WIN_DEPTH-1:0]                rdy;
  logic [WIN_DEPTH-1:0]                grant;
  logic [NUM_CLASSES-1:0][CW-1:0]      used;
  logic                                free_any;
  logic [SW-1:0]                       free_slot;
  logic                                ins_acc;
  logic                                set_en;

  assign ins_acc = ins_valid & free_any;
  assign set_en  = ins_acc & ins_dst_en;

  iss_busy_table #(.PREG_CNT(PREG_CNT)) u_busy (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (set_en),
    .set_reg (ins_dst),
    .clr_en  (wb_valid),
    .clr_reg (wb_reg),
    .busy_o  (busy)
  );

  iss_window #(.WIN_DEPTH(WIN_DEPTH), .PREG_CNT(PREG_CNT)) u_win (
    .clk         (clk),
    .rst_n       (rst_n),
    .ins_en      (ins_acc),
    .ins_cls     (ins_class),
    .ins_src_a   (ins_src_a),
    .ins_src_b   (ins_src_b),
    .agen_en     (agen_valid),
    .agen_slot   (agen_slot),
    .grant       (grant),
    .vld_o       (vld),
    .cls_o       (cls),
    .srca_o      (srca),
    .srcb_o      (srcb),
    .addr_ok_o   (addr_ok),
    .older_o     (older),
    .free_any_o  (free_any),
    .free_slot_o (free_slot)
  );

  // wakeup: readiness from registered busy bits only
  for (genvar i = 0; i < WIN_DEPTH; i++) begin : g_ready
    assign rdy[i] = vld[i] & ~busy[srca[i]] & ~busy[srcb[i]] &
                    ((cls[i] != CLS_MEM) | addr_ok[i]);
  end

  iss_select #(
    .WIN_DEPTH (WIN_DEPTH),
    .NUM_ALU   (NUM_ALU),
    .NUM_FPU   (NUM_FPU),
    .NUM_AGU   (NUM_AGU),
    .NUM_PORT  (NUM_PORT)
  ) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .rdy        (rdy),
    .cls        (cls),
    .older      (older),
    .avail_alu  (avail_alu),
    .avail_fpu  (avail_fpu),
    .avail_agu  (avail_addr),
    .avail_port (avail_port),
    .grant      (grant),
    .used       (used)
  );

  assign ins_ready = free_any;
  assign ins_slot  = free_slot;
  assign iss_grant = grant;
  assign used_alu  = used[CLS_ALU];
  assign used_fpu  = used[CLS_FPU];
  assign used_addr = used[CLS_AGU];
  assign used_port = used[CLS_MEM];

  for (genvar g = 0; g < WIN_DEPTH; g++) begin : g_chk
    assert_grant_src_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
      grant[g] |-> (!busy[srca[g]] && !busy[srcb[g]]));
    assert_mem_addr_known_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[g] && cls[g] == CLS_MEM) |-> addr_ok[g]);
  end

endmodule

// File: tb/tb_iss_sched.sv
`timescale 1ns/1ps
module tb_iss_sched;

  localparam int WIN = 4;
  localparam int PREGS = 16;
  localparam int PW = $clog2(PREGS);
  localparam int SW = $clog2(WIN);
  localparam int CW = $clog2(WIN + 1);
  localparam int N_ALU = 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           ins_valid;
  logic [1:0]     ins_class;
  logic [PW-1:0]  ins_src_a, ins_src_b, ins_dst;
  logic           ins_dst_en;
  logic           ins_ready;
  logic [SW-1:0]  ins_slot;
  logic           wb_valid;
  logic [PW-1:0]  wb_reg;
  logic           agen_valid;
  logic [SW-1:0]  agen_slot;
  logic [CW-1:0]  avail_alu, avail_fpu, avail_addr, avail_port;
  logic [WIN-1:0] iss_grant;
  logic [CW-1:0]  used_alu, used_fpu, used_addr, used_port;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  iss_sched #(
    .WIN_DEPTH(WIN), .PREG_CNT(PREGS),
    .NUM_ALU(N_ALU), .NUM_FPU(1), .NUM_AGU(1), .NUM_PORT(1)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_class(ins_class),
    .ins_src_a(ins_src_a), .ins_src_b(ins_src_b),
    .ins_dst_en(ins_dst_en), .ins_dst(ins_dst),
    .ins_ready(ins_ready), .ins_slot(ins_slot),
    .wb_valid(wb_valid), .wb_reg(wb_reg),
    .agen_valid(agen_valid), .agen_slot(agen_slot),
    .avail_alu(avail_alu), .avail_fpu(avail_fpu),
    .avail_addr(avail_addr), .avail_port(avail_port),
    .iss_grant(iss_grant),
    .used_alu(used_alu), .used_fpu(used_fpu),
    .used_addr(used_addr), .used_port(used_port)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic put(input logic [1:0] c, input int sa, input int sb,
                     input bit de, input int d, input int exp_slot);
    ins_valid  = 1'b1;
    ins_class  = c;
    ins_src_a  = PW'(sa);
    ins_src_b  = PW'(sb);
    ins_dst_en = de;
    ins_dst    = PW'(d);
    #1;
    chk("R2 insert slot", int'(ins_slot), exp_slot);
    @(negedge clk);
    ins_valid  = 1'b0;
    ins_dst_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ins_valid = 1'b0; ins_class = 2'd0; ins_src_a = '0; ins_src_b = '0;
    ins_dst_en = 1'b0; ins_dst = '0;
    wb_valid = 1'b0; wb_reg = '0; agen_valid = 1'b0; agen_slot = '0;
    avail_alu = '0; avail_fpu = '0; avail_addr = '0; avail_port = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 ins_ready", int'(ins_ready), 1);
    chk("R1 grant", int'(iss_grant), 0);
    chk("R1 ins_slot", int'(ins_slot), 0);
    chk("R1 used_alu", int'(used_alu), 0);
    avail_alu = CW'(4); avail_fpu = CW'(4); avail_addr = CW'(4); avail_port = CW'(4);
    #0.5;
    chk("R1 grant empty pool", int'(iss_grant), 0);
    avail_alu = '0; avail_fpu = '0; avail_addr = '0; avail_port = '0;
    @(negedge clk);

    // Sweep: every readiness mask against every ALU availability (R3 R4 R6 R7 R11)
    for (int m = 0; m < 16; m++) begin
      for (int i = 0; i < 4; i++) put(2'd0, 0, 0, 1'b1, 4 + i, i);
      avail_alu = CW'(4);
      @(negedge clk);
      @(negedge clk);
      avail_alu = '0;
      for (int i = 0; i < 4; i++) begin
        if (m[i]) begin
          wb_valid = 1'b1;
          wb_reg = PW'(4 + i);
          @(negedge clk);
        end
      end
      wb_valid = 1'b0;
      for (int i = 0; i < 4; i++) put(2'd0, 4 + i, 0, 1'b0, 0, i);
      #1;
      chk("R2 full pool ins_ready", int'(ins_ready), 0);
      for (int a = 0; a <= 4; a++) begin
        int lim;
        int cnt;
        int expg;
        lim = (a < N_ALU) ? a : N_ALU;
        cnt = 0;
        expg = 0;
        for (int i = 0; i < 4; i++) begin
          if (m[i] && cnt < lim) begin
            expg = expg | (1 << i);
            cnt++;
          end
        end
        avail_alu = CW'(a);
        #0.5;
        chk("R3 R4 R6 R7 grant sweep", int'(iss_grant), expg);
        chk("R11 used_alu sweep", int'(used_alu), cnt);
        avail_alu = '0;
        @(negedge clk);
      end
      avail_alu = CW'(4);
      for (int i = 0; i < 4; i++) begin
        wb_valid = 1'b1;
        wb_reg = PW'(4 + i);
        @(negedge clk);
      end
      wb_valid = 1'b0;
      repeat (3) @(negedge clk);
      avail_alu = '0;
      #1;
      chk("R10 pool drained", int'(ins_ready), 1);
      @(negedge clk);
    end

    // R5 wakeup timing
    put(2'd0, 0, 0, 1'b1, 9, 0);
    avail_alu = CW'(1);
    @(negedge clk);
    avail_alu = '0;
    put(2'd0, 9, 0, 1'b0, 0, 0);
    avail_alu = CW'(1);
    wb_valid = 1'b1;
    wb_reg = PW'(9);
    #1;
    chk("R5 no grant in completion cycle", int'(iss_grant), 0);
    @(negedge clk);
    wb_valid = 1'b0;
    #1;
    chk("R5 grant cycle after completion", int'(iss_grant), 1);
    @(negedge clk);
    avail_alu = '0;

    // R5 set wins over clear on same register
    ins_valid = 1'b1; ins_class = 2'd0; ins_src_a = '0; ins_src_b = '0;
    ins_dst_en = 1'b1; ins_dst = PW'(10);
    wb_valid = 1'b1; wb_reg = PW'(10);
    @(negedge clk);
    ins_valid = 1'b0; ins_dst_en = 1'b0; wb_valid = 1'b0;
    put(2'd0, 10, 0, 1'b0, 0, 1);
    avail_alu = CW'(2);
    #1;
    chk("R5 set wins, consumer blocked", int'(iss_grant), 1);
    @(negedge clk);
    wb_valid = 1'b1; wb_reg = PW'(10);
    @(negedge clk);
    wb_valid = 1'b0;
    @(negedge clk);
    avail_alu = '0;
    #1;
    chk("R10 drained after set-clear", int'(ins_ready), 1);
    @(negedge clk);

    // R6 R8 R10 R11 class mix: FPU, FPU, ADDR, ALU
    put(2'd1, 0, 0, 1'b0, 0, 0);
    put(2'd1, 0, 0, 1'b0, 0, 1);
    put(2'd2, 0, 0, 1'b0, 0, 2);
    put(2'd0, 0, 0, 1'b0, 0, 3);
    avail_alu = CW'(2); avail_fpu = CW'(2); avail_addr = CW'(1); avail_port = CW'(1);
    #1;
    chk("R6 R8 class mix grant", int'(iss_grant), 4'b1101);
    chk("R11 used_fpu", int'(used_fpu), 1);
    chk("R11 used_addr", int'(used_addr), 1);
    chk("R11 used_alu", int'(used_alu), 1);
    chk("R8 used_port", int'(used_port), 0);
    @(negedge clk);
    #1;
    chk("R10 retry of younger FPU", int'(iss_grant), 4'b0010);
    @(negedge clk);
    avail_alu = '0; avail_fpu = '0; avail_addr = '0; avail_port = '0;
    #1;
    chk("R10 empty after class mix", int'(ins_ready), 1);

    // R9 cache-access gating
    put(2'd3, 0, 0, 1'b0, 0, 0);
    avail_port = CW'(1); avail_addr = CW'(1);
    #1;
    chk("R9 blocked before address", int'(iss_grant), 0);
    agen_valid = 1'b1; agen_slot = '0;
    @(negedge clk);
    agen_valid = 1'b0;
    avail_port = '0;
    #1;
    chk("R9 blocked without port", int'(iss_grant), 0);
    avail_port = CW'(1);
    #0.5;
    chk("R9 granted with port", int'(iss_grant), 1);
    chk("R9 used_port", int'(used_port), 1);
    chk("R9 used_addr untouched", int'(used_addr), 0);
    @(negedge clk);
    avail_port = '0; avail_addr = '0;

    // R7 age order differs from slot order
    put(2'd0, 0, 0, 1'b0, 0, 0);
    put(2'd0, 0, 0, 1'b0, 0, 1);
    put(2'd0, 0, 0, 1'b0, 0, 2);
    avail_alu = CW'(1);
    #1;
    chk("R7 oldest of three", int'(iss_grant), 4'b0001);
    @(negedge clk);
    avail_alu = '0;
    put(2'd0, 0, 0, 1'b0, 0, 0);
    avail_alu = CW'(1);
    #0.5;
    chk("R7 reused low slot is youngest", int'(iss_grant), 4'b0010);
    avail_alu = CW'(2);
    #0.5;
    chk("R7 two oldest", int'(iss_grant), 4'b0110);
    @(negedge clk);
    @(negedge clk);
    avail_alu = '0;
    #1;
    chk("R10 final drain", int'(ins_ready), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule